// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Resolver

This block gathers up to seventeen interrupt sources into one pending register. When the processor runs an acknowledge cycle at a given level, the block answers with a vector number. Sources 1 to 7 are external lines, and each one's level is its own index. Sources 8 to 17 each take their level and vector style from a byte-wide control register. A mask register removes sources from the search, and software reaches all registers through a simple register bus.

On an acknowledge, the block looks at the pending, unmasked sources from the lowest index upward. The first source whose level equals the requested level wins. If that source is autovectored, the answer is 24 plus the level. If it is not autovectored, the vector comes from a peripheral's vector input, but only when the requested level equals the level held in control byte 4. In every other case the answer is 0. The answer is registered and appears one cycle after the request. A winning source that is not autovectored has its pending bit dropped by the acknowledge itself.

Top module: `irq_vector_resolver`

## Requirements
- R1: After reset the pending register reads 0, every control byte reads 0, and the mask register reads all ones (0x3FFFF), so every source starts masked.
- R2: Register map, using byte addresses:
  - 0x40 is the pending register (bit n is source n).
  - 0x44 is the mask register.
  - 0x4C+n (n = 0..11) is control byte n, in data bits 7:0.
  - A read returns its data on `bus_rdata` one cycle after `bus_rd`.
  - Any other address reads 0, and writes to it change nothing.
- R3: A one-cycle high on `src_assert[n]` (n = 1..17) sets pending bit n. Writing 1 to a bit at 0x40 clears that bit. A set and a clear of the same bit in the same cycle leave the bit set. Pending bit 0 always reads 0.
- R4: A source whose mask bit is 1 takes no part in an acknowledge.
- R5: Control byte layout: bit 7 is the autovector flag, bits 4:2 are the level, and bits 1:0 are the priority (stored and readable only). Source s (8..17) uses byte s-8. Sources 1..7 have level s and are always autovectored.
- R6: On an acknowledge at level L, the winner is the lowest-indexed pending, unmasked source whose level is L.
- R7: An autovectored winner yields vector 24+L.
- R8: A winner that is not autovectored yields `dev_vector` when L equals the level in control byte 4, and 0 otherwise.
- R9: If no eligible source has level L, the vector is 0.
- R10: `vector_valid` is high for exactly the cycle after each cycle with `iack_valid` high, and `vector` holds the answer in that cycle.
- R11: An acknowledge clears the pending bit of a winner that is not autovectored. It leaves the pending bit of an autovectored winner set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_assert | input | 18 | Per-source set pulses (bit 0 ignored) |
| dev_vector | input | 8 | Vector supplied by the peripheral |
| iack_valid | input | 1 | Acknowledge request |
| iack_level | input | 3 | Level being acknowledged |
| vector_valid | output | 1 | Vector answer strobe |
| vector | output | 8 | Vector number |

## Verification
Any wrong internal state shows at the ports within one acknowledge. A stale pending bit, a wrong mask bit or a corrupt control byte makes the next acknowledge at the affected level return the wrong winner's vector, or 0, in the cycle after the request. A pending bit that fails to clear on a non-autovectored acknowledge shows up on the very next acknowledge at that level as a repeated vector, and it also shows in a read of the pending register two cycles later. The sweep loads many computed control and mask patterns and then acknowledges every level, so a fault in a single field or a single scan position changes some visible vector.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef struct packed {
    logic       avec;
    logic [1:0] rsvd;
    logic [2:0] level;
    logic [1:0] prio;
  } ctl_byte_t;
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
#(
  parameter int NUM_SRC   = 18,
  parameter int NUM_CTL   = 12,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int PEND_ADDR = 'h40,
  parameter int MASK_ADDR = 'h44,
  parameter int CTL_BASE  = 'h4C
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NUM_SRC-1:0]      src_assert,
  input  logic [NUM_SRC-1:0]      ack_clr,
  output logic [NUM_SRC-1:0]      pend_q,
  output logic [NUM_SRC-1:0]      mask_q,
  output ctl_byte_t [NUM_CTL-1:0] ctl_q
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic              wr_pend, wr_mask;
  logic [NUM_SRC-1:0] pend_n;
  logic [DATA_W-1:0]  rd_mux;
  logic               wdata_unused;

  assign wr_pend      = bus_wr && (bus_addr == ADDR_W'(PEND_ADDR));
  assign wr_mask      = bus_wr && (bus_addr == ADDR_W'(MASK_ADDR));
  assign wdata_unused = ^bus_wdata[DATA_W-1:NUM_SRC];

  // set has priority over both clear paths; bit 0 never holds a source
  always_comb begin
    pend_n = pend_q;
    if (wr_pend) pend_n = pend_n & ~bus_wdata[NUM_SRC-1:0];
    pend_n    = pend_n & ~ack_clr;
    pend_n    = pend_n | src_assert;
    pend_n[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= pend_n;
      if (wr_mask) mask_q <= bus_wdata[NUM_SRC-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst)
        ctl_q[i] <= '0;
      else if (bus_wr && (bus_addr == ADDR_W'(CTL_BASE + i)))
        ctl_q[i] <= bus_wdata[7:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(PEND_ADDR)) rd_mux = {{PAD_W{1'b0}}, pend_q};
    if (bus_addr == ADDR_W'(MASK_ADDR)) rd_mux = {{PAD_W{1'b0}}, mask_q};
    for (int i = 0; i < NUM_CTL; i++)
      if (bus_addr == ADDR_W'(CTL_BASE + i))
        rd_mux = {{(DATA_W-8){1'b0}}, ctl_q[i]};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R1
  mask_reset_chk: assert property (@(posedge clk) $past(rst) |-> (mask_q == '1 && pend_q == '0));

  // R3
  src_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|src_assert[NUM_SRC-1:1]) |=>
      ((pend_q & $past({src_assert[NUM_SRC-1:1], 1'b0})) == $past({src_assert[NUM_SRC-1:1], 1'b0})));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pend |=> ((pend_q & $past(bus_wdata[NUM_SRC-1:0] & ~src_assert)) == '0));
endmodule

// File: rtl/irqv_scan.sv
module irqv_scan #(
  parameter int NUM_SRC       = 18,
  parameter int FIRST_CTL_SRC = 8,
  parameter int LVL_W         = 3,
  localparam int NUM_MAP      = NUM_SRC - FIRST_CTL_SRC,
  localparam int IDX_W        = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            elig,
  input  logic [NUM_MAP-1:0][LVL_W-1:0] cfg_lvl,
  input  logic [NUM_MAP-1:0]            cfg_av,
  input  logic [LVL_W-1:0]              level,
  output logic                          found,
  output logic [IDX_W-1:0]              win_idx,
  output logic                          win_avec
);
  logic [LVL_W-1:0] src_lvl [NUM_SRC];
  logic             src_av  [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s < FIRST_CTL_SRC) begin : g_ext
      assign src_lvl[s] = LVL_W'(s);
      assign src_av[s]  = 1'b1;
    end else begin : g_cfg
      assign src_lvl[s] = cfg_lvl[s-FIRST_CTL_SRC];
      assign src_av[s]  = cfg_av[s-FIRST_CTL_SRC];
    end
  end

  // descending walk: the lowest matching index is written last
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_avec = 1'b0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (elig[s] && (src_lvl[s] == level)) begin
        found    = 1'b1;
        win_idx  = IDX_W'(s);
        win_avec = src_av[s];
      end
    end
  end
endmodule

// File: rtl/irqv_vecgen.sv
module irqv_vecgen #(
  parameter int LVL_W     = 3,
  parameter int VEC_W     = 8,
  parameter int AVEC_BASE = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iack_valid,
  input  logic [LVL_W-1:0] iack_level,
  input  logic             found,
  input  logic             win_avec,
  input  logic [LVL_W-1:0] ref_level,
  input  logic [VEC_W-1:0] dev_vector,
  output logic             vector_valid,
  output logic [VEC_W-1:0] vector
);
  logic [VEC_W-1:0] vec_n;

  always_comb begin
    if (!found)                      vec_n = '0;
    else if (win_avec)               vec_n = VEC_W'(AVEC_BASE) + VEC_W'(iack_level);
    else if (iack_level == ref_level) vec_n = dev_vector;
    else                             vec_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vector_valid <= 1'b0;
      vector       <= '0;
    end else begin
      vector_valid <= iack_valid;
      if (iack_valid) vector <= vec_n;
    end
  end
endmodule

// File: rtl/irq_vector_resolver.sv
module irq_vector_resolver
  import irqv_pkg::*;
#(
  parameter int NUM_SRC       = 18,
  parameter int FIRST_CTL_SRC = 8,
  parameter int NUM_CTL       = 12,
  parameter int REF_CTL       = 4,
  parameter int ADDR_W        = 10,
  parameter int DATA_W        = 32,
  parameter int VEC_W         = 8,
  parameter int AVEC_BASE     = 24,
  parameter int PEND_ADDR     = 'h40,
  parameter int MASK_ADDR     = 'h44,
  parameter int CTL_BASE      = 'h4C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_assert,
  input  logic [VEC_W-1:0]   dev_vector,
  input  logic               iack_valid,
  input  logic [2:0]         iack_level,
  output logic               vector_valid,
  output logic [VEC_W-1:0]   vector
);
  localparam int LVL_W   = 3;
  localparam int NUM_MAP = NUM_SRC - FIRST_CTL_SRC;
  localparam int IDX_W   = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]            pend_q, mask_q, ack_clr;
  ctl_byte_t [NUM_CTL-1:0]       ctl_q;
  logic [NUM_MAP-1:0][LVL_W-1:0] cfg_lvl;
  logic [NUM_MAP-1:0]            cfg_av;
  logic                          found, win_avec;
  logic [IDX_W-1:0]              win_idx;
  logic                          ctl_unused;

  irqv_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CTL(NUM_CTL), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PEND_ADDR(PEND_ADDR), .MASK_ADDR(MASK_ADDR), .CTL_BASE(CTL_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_assert(src_assert),
    .ack_clr(ack_clr), .pend_q(pend_q), .mask_q(mask_q), .ctl_q(ctl_q)
  );

  for (genvar m = 0; m < NUM_MAP; m++) begin : g_map
    assign cfg_lvl[m] = ctl_q[m].level;
    assign cfg_av[m]  = ctl_q[m].avec;
  end
  assign ctl_unused = ^ctl_q;

  irqv_scan #(
    .NUM_SRC(NUM_SRC), .FIRST_CTL_SRC(FIRST_CTL_SRC), .LVL_W(LVL_W)
  ) u_scan (
    .elig(pend_q & ~mask_q), .cfg_lvl(cfg_lvl), .cfg_av(cfg_av),
    .level(iack_level), .found(found), .win_idx(win_idx), .win_avec(win_avec)
  );

  always_comb begin
    ack_clr = '0;
    if (iack_valid && found && !win_avec) ack_clr[win_idx] = 1'b1;
  end

  irqv_vecgen #(
    .LVL_W(LVL_W), .VEC_W(VEC_W), .AVEC_BASE(AVEC_BASE)
  ) u_vec (
    .clk(clk), .rst(rst), .iack_valid(iack_valid), .iack_level(iack_level),
    .found(found), .win_avec(win_avec), .ref_level(ctl_q[REF_CTL].level),
    .dev_vector(dev_vector), .vector_valid(vector_valid), .vector(vector)
  );

  // R10
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    iack_valid |=> vector_valid);

  // R10
  strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !iack_valid |=> !vector_valid);

  // R7
  avec_value_chk: assert property (@(posedge clk) disable iff (rst)
    (iack_valid && found && win_avec) |=> (vector == VEC_W'(AVEC_BASE) + VEC_W'($past(iack_level))));

  // R9
  no_match_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (iack_valid && !found) |=> (vector == '0));

  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (iack_valid && found && !win_avec && !src_assert[win_idx]) |=> !pend_q[$past(win_idx)]);
endmodule

// File: tb/sim_irq_vector_resolver.sv
`timescale 1ns/1ps
module sim_irq_vector_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [17:0] src_assert = '0;
  logic [7:0]  dev_vector = '0;
  logic        iack_valid = 1'b0;
  logic [2:0]  iack_level = '0;
  logic        vector_valid;
  logic [7:0]  vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [17:0] pend_m;
  logic [17:0] mask_m;
  logic [7:0]  ctl_m [12];
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  irq_vector_resolver u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_assert(src_assert),
    .dev_vector(dev_vector), .iack_valid(iack_valid), .iack_level(iack_level),
    .vector_valid(vector_valid), .vector(vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 10'h40) pend_m = pend_m & ~d[17:0];
    if (a == 10'h44) mask_m = d[17:0];
    if (a >= 10'h4C && a <= 10'h57) ctl_m[a - 10'h4C] = d[7:0];
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [17:0] v);
    @(negedge clk);
    src_assert = v;
    @(negedge clk);
    src_assert = '0;
    pend_m = (pend_m | v) & ~18'h1;
  endtask

  // expected answer from the requirements; clr is the index whose pending bit drops
  function automatic void resolve(input int lvl, output logic [7:0] e, output int clr);
    e = 8'h0; clr = 0;
    for (int s = 1; s < 18; s++) begin
      int sl; bit sa;
      if (!pend_m[s] || mask_m[s]) continue;
      sl = (s < 8) ? s : int'(ctl_m[s-8][4:2]);
      sa = (s < 8) ? 1'b1 : ctl_m[s-8][7];
      if (sl != lvl) continue;
      if (sa) e = 8'(24 + lvl);
      else begin
        clr = s;
        e = (lvl == int'(ctl_m[4][4:2])) ? dev_vector : 8'h0;
      end
      return;
    end
  endfunction

  task automatic ack(input int lvl, input string req);
    logic [7:0] e; int c;
    resolve(lvl, e, c);
    @(negedge clk);
    iack_valid = 1'b1; iack_level = lvl[2:0];
    @(negedge clk);
    iack_valid = 1'b0;
    chk("R10 strobe", {31'b0, vector_valid}, 32'd1);
    chk(req, {24'b0, vector}, {24'b0, e});
    if (c > 0) pend_m[c] = 1'b0;
    @(negedge clk);
    chk("R10 idle", {31'b0, vector_valid}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    pend_m = '0; mask_m = '1;
    for (int i = 0; i < 12; i++) ctl_m[i] = 8'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(10'h40, d); chk("R1 pending", d, 32'h0);
    rd(10'h44, d); chk("R1 mask", d, 32'h3FFFF);
    for (int i = 0; i < 12; i++) begin
      rd(10'(10'h4C + i), d); chk("R1 ctl", d, 32'h0);
    end
    // R2 unmapped read and write
    wr(10'h48, 32'hFFFF_FFFF);
    rd(10'h48, d); chk("R2 unmapped", d, 32'h0);
    rd(10'h44, d); chk("R2 unmapped write no effect", d, 32'h3FFFF);

    // R4 masked source ignored
    pulse(18'h8);
    rd(10'h40, d); chk("R3 set", d, 32'h8);
    ack(3, "R4 masked");

    // R2 mask write, R5/R7 external autovector, R11 no clear
    wr(10'h44, 32'h0);
    rd(10'h44, d); chk("R2 mask rw", d, 32'h0);
    ack(3, "R7 external avec");
    rd(10'h40, d); chk("R11 avec keeps pending", d, 32'h8);

    // R6 ordering, R8 device vector, R11 clear, R9 none
    dev_vector = 8'h40;
    wr(10'h4C, 32'h0C);
    wr(10'h50, 32'h0D);
    rd(10'h50, d); chk("R2 ctl byte", d, 32'h0D);
    pulse(18'h100);
    ack(3, "R6 lowest index");
    wr(10'h40, 32'h8);
    rd(10'h40, d); chk("R3 w1c", d, 32'h100);
    ack(3, "R8 device vector");
    rd(10'h40, d); chk("R11 cleared", d, 32'h0);
    ack(3, "R9 no match");

    // R8 level mismatch to byte 4 gives 0
    wr(10'h4D, 32'h14);
    pulse(18'h200);
    ack(5, "R8 mismatch zero");
    rd(10'h40, d); chk("R11 cleared mismatch", d, 32'h0);

    // R3 set wins over clear, bit 0 ignored
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 10'h40; bus_wdata = 32'h400; src_assert = 18'h401;
    @(negedge clk);
    bus_wr = 1'b0; src_assert = '0;
    pend_m = 18'h400;
    rd(10'h40, d); chk("R3 set beats clear", d, 32'h400);

    // R5 priority bits stored, avec flag in bit 7
    wr(10'h4E, 32'h9B);
    rd(10'h4E, d); chk("R5 byte fields", d, 32'h9B);
    ack(6, "R5 avec via byte");

    // sweep: computed configurations, every level
    for (int r = 0; r < 60; r++) begin
      logic [31:0] a, b;
      for (int i = 0; i < 12; i++) begin
        a = rnd();
        wr(10'(10'h4C + i), {24'b0, a[23:16]});
      end
      a = rnd(); b = rnd();
      wr(10'h44, {14'b0, a[17:0] & b[17:0]});
      wr(10'h40, 32'h3FFFF);
      a = rnd();
      dev_vector = a[31:24];
      pulse(a[17:0]);
      rd(10'h40, d); chk("R3 sweep pending", d, {14'b0, pend_m});
      for (int l = 0; l < 8; l++) ack(l, "R6 sweep");
      for (int l = 7; l >= 0; l--) ack(l, "R11 sweep repeat");
      rd(10'h40, d); chk("R11 sweep pending", d, {14'b0, pend_m});
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule